// File: doc/BRIEF.md
# Indexed Address Translation Bridge

This bridge gives a processor access to a 28-bit controller command space through only two 32-bit host registers. The host first stores a complete control word in the control register. Each access to the data register then becomes one request on a downstream valid/ready port, built from the stored control word. A read from the data register holds back the host response until the downstream side returns the data. A write is acknowledged once the downstream side accepts the request.

The stored control word is split into fields so that downstream logic can route each access:
- **Map selector.** Four request families:
  - direct buffer access
  - page transfer by programmed I/O
  - high-level command plane
  - raw device cycle
- **Bank number.** Given both as a binary value and as a one-hot select.
- **Page field.** The low-order bits.
- **Cycle type.** For raw device cycles only: command, address or data.

The raw-cycle code 3 is reserved. A data access made with that code is answered with an error and is never forwarded. The stored word stays in place until the next control write, so a run of data accesses can share one setup.

Top module: `idx_window_bridge`

## Requirements
- R1: After reset `host_ready`=1, `dn_valid`=0 and `rsp_valid`=0, and the stored control word is 0, so a control-register read returns 0.
- R2: A host write at byte offset 0x00 stores `host_wdata[27:0]` as the control word and ignores bits 31:28. `rsp_valid`=1 with `rsp_err`=0 follows on the next cycle, with no downstream request. A host read at 0x00 returns the stored word with bits 31:28 zero.
- R3: A host write at offset 0x10 raises `dn_valid` with `dn_write`=1 and `dn_wdata`=`host_wdata` on the cycle after acceptance. The host sees `rsp_valid`=1, `rsp_err`=0 on the cycle after the downstream handshake (`dn_valid`&`dn_ready`).
- R4: A host read at offset 0x10 raises `dn_valid` with `dn_write`=0. `host_ready` stays 0 from acceptance until the response. The response carries `dn_rdata` on the cycle after `dn_rvalid`, which is taken only after the request handshake.
- R5: `dn_map` equals control bits 27:26 (0 buffer, 1 programmed-I/O page, 2 command plane, 3 raw device cycle). `dn_bank` equals bits 25:24, and `dn_bank_sel` has exactly bit `dn_bank` set.
- R6: `dn_page` equals control bits 23:0, the page address in maps 1 and 2.
- R7: When `dn_map`=3, `dn_cycle` equals control bits 1:0 (0 command, 1 address, 2 data). In every other map `dn_cycle`=0.
- R8: Data accesses that follow without a new control write reuse the stored word unchanged.
- R9: A data access while map=3 and bits 1:0=3 gives `rsp_valid`=1 with `rsp_err`=1 on the next cycle, and `dn_valid` stays 0.
- R10: While `dn_valid`=1 and `dn_ready`=0, the request fields and `dn_wdata` hold steady and `dn_valid` stays 1.
- R11: An access at any offset other than 0x00 or 0x10 gives `rsp_valid`=1 with `rsp_err`=1 on the next cycle. It leaves the stored word unchanged and makes no downstream request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_valid | input | 1 | Host access request |
| host_ready | output | 1 | Bridge can accept a host access |
| host_write | input | 1 | 1 for write, 0 for read |
| host_addr | input | 5 | Byte offset in the window |
| host_wdata | input | 32 | Host write data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Response is an error |
| rsp_rdata | output | 32 | Read data of the response |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream accepts request |
| dn_write | output | 1 | Downstream request is a write |
| dn_map | output | 2 | Map selector of the stored word |
| dn_bank | output | 2 | Bank number |
| dn_bank_sel | output | 4 | One-hot bank select |
| dn_page | output | 24 | Low-order page/address field |
| dn_cycle | output | 2 | Raw-cycle type, 0 outside map 3 |
| dn_wdata | output | 32 | Downstream write data |
| dn_rvalid | input | 1 | Downstream read data valid |
| dn_rdata | input | 32 | Downstream read data |

## Verification
A corrupted stored word shows up on the routing outputs from the very next cycle. It also shows up on the next control-register read. The map, bank, page and cycle checks therefore catch a bad latch or a bad field slice within one access. A sequencer stuck in the wrong state shows at the ports within a cycle or two: `host_ready` stays low, `dn_valid` drops before its handshake, a response is missing, or a reserved or unmapped access leaks onto `dn_valid`. The bench holds `dn_ready` and `dn_rvalid` back for several cycles so that each of these states stays open long enough to be observed.

// File: rtl/idxb_pkg.sv
package idxb_pkg;

  typedef enum logic [1:0] {
    MAP_BUF = 2'd0,
    MAP_PIO = 2'd1,
    MAP_CMD = 2'd2,
    MAP_DEV = 2'd3
  } map_e;

  typedef enum logic [1:0] {
    CYC_CMD  = 2'd0,
    CYC_ADDR = 2'd1,
    CYC_DATA = 2'd2,
    CYC_RSVD = 2'd3
  } cyc_e;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_CTRL = 2'd1,
    ACC_DATA = 2'd2
  } acc_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } seq_e;

endpackage

// File: rtl/idxb_offset_decode.sv
module idxb_offset_decode
  import idxb_pkg::*;
#(
  parameter int unsigned OFS_W    = 5,
  parameter int unsigned CTRL_OFS = 0,
  parameter int unsigned DATA_OFS = 16
) (
  input  logic [OFS_W-1:0] host_addr,
  output acc_e             kind
);

  function automatic acc_e classify(input logic [OFS_W-1:0] a);
    if (a == OFS_W'(CTRL_OFS))      return ACC_CTRL;
    else if (a == OFS_W'(DATA_OFS)) return ACC_DATA;
    else                            return ACC_NONE;
  endfunction

  always_comb kind = classify(host_addr);

endmodule

// File: rtl/idxb_ctrl_reg.sv
module idxb_ctrl_reg
  import idxb_pkg::*;
#(
  parameter int unsigned CTRL_W = 28,
  parameter int unsigned BANKS  = 4,
  localparam int unsigned MAP_W  = 2,
  localparam int unsigned CYC_W  = 2,
  localparam int unsigned BANK_W = $clog2(BANKS),
  localparam int unsigned PAGE_W = CTRL_W - MAP_W - BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CTRL_W-1:0] din,
  output logic [CTRL_W-1:0] word,
  output logic [MAP_W-1:0]  map,
  output logic [BANK_W-1:0] bank,
  output logic [BANKS-1:0]  bank_sel,
  output logic [PAGE_W-1:0] page,
  output logic [CYC_W-1:0]  cycle,
  output logic              reserved
);

  function automatic logic [MAP_W-1:0] map_of(input logic [CTRL_W-1:0] w);
    return w[CTRL_W-1 -: MAP_W];
  endfunction

  function automatic logic [BANK_W-1:0] bank_of(input logic [CTRL_W-1:0] w);
    return w[CTRL_W-MAP_W-1 -: BANK_W];
  endfunction

  function automatic logic [PAGE_W-1:0] page_of(input logic [CTRL_W-1:0] w);
    return w[PAGE_W-1:0];
  endfunction

  function automatic logic [CYC_W-1:0] cycle_of(input logic [CTRL_W-1:0] w);
    if (map_of(w) == MAP_DEV) return w[CYC_W-1:0];
    else                      return '0;
  endfunction

  function automatic logic is_reserved(input logic [CTRL_W-1:0] w);
    return (map_of(w) == MAP_DEV) && (w[CYC_W-1:0] == CYC_RSVD);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    word <= '0;
    else if (load) word <= din;
  end

  always_comb begin
    map      = map_of(word);
    bank     = bank_of(word);
    page     = page_of(word);
    cycle    = cycle_of(word);
    reserved = is_reserved(word);
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    assign bank_sel[b] = (bank == BANK_W'(b));
  end

endmodule

// File: rtl/idxb_seq.sv
module idxb_seq
  import idxb_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_valid,
  input  logic              host_write,
  input  acc_e              kind,
  input  logic              reserved,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [DATA_W-1:0] ctrl_rdback,
  output logic              host_ready,
  output logic              acc_fire,
  output logic              ctrl_load,
  output logic              rd_wait,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic              dn_write,
  output logic [DATA_W-1:0] dn_wdata,
  input  logic              dn_rvalid,
  input  logic [DATA_W-1:0] dn_rdata
);

  seq_e st;

  assign host_ready = (st == ST_IDLE);
  assign acc_fire   = host_valid && host_ready;
  assign ctrl_load  = acc_fire && (kind == ACC_CTRL) && host_write;
  assign dn_valid   = (st == ST_ISSUE);
  assign rd_wait    = (st == ST_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
      dn_write  <= 1'b0;
      dn_wdata  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (acc_fire) begin
            unique case (kind)
              ACC_CTRL: begin
                rsp_valid <= 1'b1;
                rsp_err   <= 1'b0;
                rsp_rdata <= host_write ? '0 : ctrl_rdback;
              end
              ACC_DATA: begin
                if (reserved) begin
                  rsp_valid <= 1'b1;
                  rsp_err   <= 1'b1;
                  rsp_rdata <= '0;
                end else begin
                  st       <= ST_ISSUE;
                  dn_write <= host_write;
                  dn_wdata <= host_write ? host_wdata : '0;
                end
              end
              default: begin
                rsp_valid <= 1'b1;
                rsp_err   <= 1'b1;
                rsp_rdata <= '0;
              end
            endcase
          end
        end
        ST_ISSUE: begin
          if (dn_ready) begin
            if (dn_write) begin
              rsp_valid <= 1'b1;
              rsp_err   <= 1'b0;
              rsp_rdata <= '0;
              st        <= ST_IDLE;
            end else begin
              st <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (dn_rvalid) begin
            rsp_valid <= 1'b1;
            rsp_err   <= 1'b0;
            rsp_rdata <= dn_rdata;
            st        <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/idx_window_bridge.sv
module idx_window_bridge
  import idxb_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned CTRL_W   = 28,
  parameter int unsigned BANKS    = 4,
  parameter int unsigned OFS_W    = 5,
  parameter int unsigned CTRL_OFS = 0,
  parameter int unsigned DATA_OFS = 16,
  localparam int unsigned BANK_W  = $clog2(BANKS),
  localparam int unsigned PAGE_W  = CTRL_W - 2 - BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_valid,
  output logic              host_ready,
  input  logic              host_write,
  input  logic [OFS_W-1:0]  host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic              dn_write,
  output logic [1:0]        dn_map,
  output logic [BANK_W-1:0] dn_bank,
  output logic [BANKS-1:0]  dn_bank_sel,
  output logic [PAGE_W-1:0] dn_page,
  output logic [1:0]        dn_cycle,
  output logic [DATA_W-1:0] dn_wdata,
  input  logic              dn_rvalid,
  input  logic [DATA_W-1:0] dn_rdata
);

  acc_e              kind;
  logic              acc_fire;
  logic              ctrl_load;
  logic              rd_wait;
  logic              rsvd_code;
  logic [CTRL_W-1:0] ctrl_word;
  logic [DATA_W-1:0] ctrl_rdback;

  assign ctrl_rdback = {{(DATA_W-CTRL_W){1'b0}}, ctrl_word};

  idxb_offset_decode #(
    .OFS_W(OFS_W), .CTRL_OFS(CTRL_OFS), .DATA_OFS(DATA_OFS)
  ) u_dec (
    .host_addr(host_addr),
    .kind     (kind)
  );

  idxb_ctrl_reg #(
    .CTRL_W(CTRL_W), .BANKS(BANKS)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (ctrl_load),
    .din     (host_wdata[CTRL_W-1:0]),
    .word    (ctrl_word),
    .map     (dn_map),
    .bank    (dn_bank),
    .bank_sel(dn_bank_sel),
    .page    (dn_page),
    .cycle   (dn_cycle),
    .reserved(rsvd_code)
  );

  idxb_seq #(
    .DATA_W(DATA_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_valid (host_valid),
    .host_write (host_write),
    .kind       (kind),
    .reserved   (rsvd_code),
    .host_wdata (host_wdata),
    .ctrl_rdback(ctrl_rdback),
    .host_ready (host_ready),
    .acc_fire   (acc_fire),
    .ctrl_load  (ctrl_load),
    .rd_wait    (rd_wait),
    .rsp_valid  (rsp_valid),
    .rsp_err    (rsp_err),
    .rsp_rdata  (rsp_rdata),
    .dn_valid   (dn_valid),
    .dn_ready   (dn_ready),
    .dn_write   (dn_write),
    .dn_wdata   (dn_wdata),
    .dn_rvalid  (dn_rvalid),
    .dn_rdata   (dn_rdata)
  );

endmodule

// File: rtl/idxb_checker.sv
module idxb_checker #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BANKS  = 4,
  parameter int unsigned BANK_W = 2,
  parameter int unsigned PAGE_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_ready,
  input logic              acc_fire,
  input logic              ctrl_load,
  input logic              rd_wait,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              dn_valid,
  input logic              dn_ready,
  input logic              dn_write,
  input logic [1:0]        dn_map,
  input logic [BANK_W-1:0] dn_bank,
  input logic [BANKS-1:0]  dn_bank_sel,
  input logic [PAGE_W-1:0] dn_page,
  input logic [1:0]        dn_cycle,
  input logic [DATA_W-1:0] dn_wdata,
  input logic              dn_rvalid,
  input logic [DATA_W-1:0] dn_rdata
);

  // R5: one bank select, matching the bank number
  assert_bank_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(dn_bank_sel) == 1) && dn_bank_sel[dn_bank]);

  // R7: cycle type is zero outside the raw-cycle map
  assert_cycle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_map != 2'b11) |-> (dn_cycle == 2'b00));

  // R9: reserved raw-cycle code never reaches the downstream port
  assert_no_rsvd_issue_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> !((dn_map == 2'b11) && (dn_cycle == 2'b11)));

  // R10: stalled request holds steady
  assert_hold_request_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_write) && $stable(dn_wdata)
      && $stable(dn_page) && $stable(dn_map) && $stable(dn_bank)));

  // R4: host is stalled while a downstream access is open
  assert_host_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid || rd_wait) |-> !host_ready);

  // R4: returned read data reaches the host one cycle later
  assert_read_return_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_wait && dn_rvalid) |=> (rsp_valid && !rsp_err && (rsp_rdata == $past(dn_rdata))));

  // R3: accepted downstream write is acknowledged next cycle
  assert_write_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && dn_ready && dn_write) |=> (rsp_valid && !rsp_err));

  // R2: control write is acknowledged without a downstream request
  assert_ctrl_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_load |=> (rsp_valid && !rsp_err && !dn_valid));

  // R1: no response without a preceding accepted access or downstream event
  assert_rsp_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_fire || dn_valid || rd_wait) |=> !rsp_valid);

endmodule

bind idx_window_bridge idxb_checker #(
  .DATA_W(DATA_W), .BANKS(BANKS), .BANK_W(BANK_W), .PAGE_W(PAGE_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_ready (host_ready),
  .acc_fire   (acc_fire),
  .ctrl_load  (ctrl_load),
  .rd_wait    (rd_wait),
  .rsp_valid  (rsp_valid),
  .rsp_err    (rsp_err),
  .rsp_rdata  (rsp_rdata),
  .dn_valid   (dn_valid),
  .dn_ready   (dn_ready),
  .dn_write   (dn_write),
  .dn_map     (dn_map),
  .dn_bank    (dn_bank),
  .dn_bank_sel(dn_bank_sel),
  .dn_page    (dn_page),
  .dn_cycle   (dn_cycle),
  .dn_wdata   (dn_wdata),
  .dn_rvalid  (dn_rvalid),
  .dn_rdata   (dn_rdata)
);

// File: tb/sim_idx_window_bridge.sv
module sim_idx_window_bridge;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_valid = 1'b0;
  logic        host_ready;
  logic        host_write = 1'b0;
  logic [4:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic        rsp_valid;
  logic        rsp_err;
  logic [31:0] rsp_rdata;
  logic        dn_valid;
  logic        dn_ready = 1'b0;
  logic        dn_write;
  logic [1:0]  dn_map;
  logic [1:0]  dn_bank;
  logic [3:0]  dn_bank_sel;
  logic [23:0] dn_page;
  logic [1:0]  dn_cycle;
  logic [31:0] dn_wdata;
  logic        dn_rvalid = 1'b0;
  logic [31:0] dn_rdata = '0;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  idx_window_bridge u0 (
    .clk(clk), .rst_n(rst_n),
    .host_valid(host_valid), .host_ready(host_ready), .host_write(host_write),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_write(dn_write),
    .dn_map(dn_map), .dn_bank(dn_bank), .dn_bank_sel(dn_bank_sel),
    .dn_page(dn_page), .dn_cycle(dn_cycle), .dn_wdata(dn_wdata),
    .dn_rvalid(dn_rvalid), .dn_rdata(dn_rdata)
  );

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !done) begin
      done = 1;
      fails = fails + 1;
      $display("FAIL watchdog: run did not complete");
      summary();
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  // drive one host access; returns at the negedge just after acceptance
  task automatic host_issue(input bit wr, input logic [4:0] ofs, input logic [31:0] wd);
    @(negedge clk);
    host_valid = 1'b1; host_write = wr; host_addr = ofs; host_wdata = wd;
    @(negedge clk);
    host_valid = 1'b0; host_write = 1'b0; host_wdata = '0;
  endtask

  task automatic set_ctrl(input string req, input logic [31:0] w);
    host_issue(1'b1, 5'h00, w);
    chk(req, "ctrl ack valid", {31'd0, rsp_valid}, 32'd1);
    chk(req, "ctrl ack err", {31'd0, rsp_err}, 32'd0);
    chk(req, "ctrl no downstream", {31'd0, dn_valid}, 32'd0);
  endtask

  task automatic expect_fields(input string req, input logic [31:0] w);
    logic [1:0] m;
    m = 2'((w >> 26) & 32'h3);
    chk(req, "map", {30'd0, dn_map}, {30'd0, m});
    chk(req, "bank", {30'd0, dn_bank}, (w >> 24) & 32'h3);
    chk(req, "bank_sel", {28'd0, dn_bank_sel}, 32'd1 << ((w >> 24) & 32'h3));
    chk(req, "page", {8'd0, dn_page}, w & 32'h00FF_FFFF);
    chk(req, "cycle", {30'd0, dn_cycle}, (m == 2'd3) ? (w & 32'h3) : 32'd0);
  endtask

  // data write with a stall of 'stall' cycles on dn_ready
  task automatic data_write(input string req, input logic [31:0] w,
                            input logic [31:0] wd, input int stall);
    host_issue(1'b1, 5'h10, wd);
    chk(req, "dn_valid raised", {31'd0, dn_valid}, 32'd1);
    chk(req, "dn_write", {31'd0, dn_write}, 32'd1);
    chk(req, "dn_wdata", dn_wdata, wd);
    chk(req, "host stalled", {31'd0, host_ready}, 32'd0);
    expect_fields(req, w);
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk("R10", "request held", {31'd0, dn_valid}, 32'd1);
      chk("R10", "wdata held", dn_wdata, wd);
      chk("R10", "page held", {8'd0, dn_page}, w & 32'h00FF_FFFF);
    end
    dn_ready = 1'b1;
    @(negedge clk);
    dn_ready = 1'b0;
    chk("R3", "write ack valid", {31'd0, rsp_valid}, 32'd1);
    chk("R3", "write ack err", {31'd0, rsp_err}, 32'd0);
    chk("R3", "request dropped", {31'd0, dn_valid}, 32'd0);
    chk("R3", "host ready again", {31'd0, host_ready}, 32'd1);
  endtask

  // r1_: reset state
  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "host_ready", {31'd0, host_ready}, 32'd1);
    chk("R1", "dn_valid", {31'd0, dn_valid}, 32'd0);
    chk("R1", "rsp_valid", {31'd0, rsp_valid}, 32'd0);
    host_issue(1'b0, 5'h00, '0);
    chk("R1", "ctrl readback", rsp_rdata, 32'd0);
  endtask

  // r2_: control write and readback, upper bits dropped
  task automatic t_ctrl();
    set_ctrl("R2", 32'hFA5A_1234);
    @(negedge clk);
    chk("R2", "ack is one cycle", {31'd0, rsp_valid}, 32'd0);
    host_issue(1'b0, 5'h00, '0);
    chk("R2", "readback valid", {31'd0, rsp_valid}, 32'd1);
    chk("R2", "readback value", rsp_rdata, 32'h0A5A_1234);
    chk("R2", "no downstream", {31'd0, dn_valid}, 32'd0);
  endtask

  // r5_, r6_: fields for a page-map word
  task automatic t_page_fields();
    set_ctrl("R6", 32'h0512_3456);
    data_write("R6", 32'h0512_3456, 32'hCAFE_0001, 2);
    set_ctrl("R5", 32'h0BAB_CDEF);
    data_write("R5", 32'h0BAB_CDEF, 32'h1111_2222, 0);
  endtask

  // r7_: raw cycles of each type in map 3
  task automatic t_cycles();
    for (int c = 0; c < 3; c++) begin
      logic [31:0] w;
      w = 32'h0E00_0000 | 32'(c) | 32'h0000_0400;
      set_ctrl("R7", w);
      data_write("R7", w, 32'h0000_00A0 + 32'(c), 1);
    end
  endtask

  // r4_: data read with delayed return
  task automatic t_read();
    set_ctrl("R4", 32'h0400_0042);
    host_issue(1'b0, 5'h10, '0);
    chk("R4", "read request", {31'd0, dn_valid}, 32'd1);
    chk("R4", "read type", {31'd0, dn_write}, 32'd0);
    expect_fields("R4", 32'h0400_0042);
    dn_ready = 1'b1;
    @(negedge clk);
    dn_ready = 1'b0;
    chk("R4", "request closed", {31'd0, dn_valid}, 32'd0);
    chk("R4", "still stalled", {31'd0, host_ready}, 32'd0);
    chk("R4", "no early response", {31'd0, rsp_valid}, 32'd0);
    repeat (3) @(negedge clk);
    chk("R4", "stalled after wait", {31'd0, host_ready}, 32'd0);
    dn_rvalid = 1'b1; dn_rdata = 32'h5EED_BEEF;
    @(negedge clk);
    dn_rvalid = 1'b0; dn_rdata = '0;
    chk("R4", "read response", {31'd0, rsp_valid}, 32'd1);
    chk("R4", "read data", rsp_rdata, 32'h5EED_BEEF);
    chk("R4", "read err", {31'd0, rsp_err}, 32'd0);
    chk("R4", "ready after read", {31'd0, host_ready}, 32'd1);
  endtask

  // r8_: repeated data accesses reuse the stored word
  task automatic t_reuse();
    set_ctrl("R8", 32'h0633_0007);
    data_write("R8", 32'h0633_0007, 32'h0000_0001, 0);
    data_write("R8", 32'h0633_0007, 32'h0000_0002, 1);
    host_issue(1'b0, 5'h00, '0);
    chk("R8", "word kept", rsp_rdata, 32'h0633_0007);
  endtask

  // r9_: reserved raw-cycle code
  task automatic t_reserved();
    set_ctrl("R9", 32'h0D00_0003);
    host_issue(1'b1, 5'h10, 32'h1234_5678);
    chk("R9", "error response", {31'd0, rsp_valid}, 32'd1);
    chk("R9", "error flag", {31'd0, rsp_err}, 32'd1);
    chk("R9", "not forwarded", {31'd0, dn_valid}, 32'd0);
    @(negedge clk);
    chk("R9", "still not forwarded", {31'd0, dn_valid}, 32'd0);
    host_issue(1'b0, 5'h10, '0);
    chk("R9", "read error flag", {31'd0, rsp_err}, 32'd1);
    chk("R9", "read not forwarded", {31'd0, dn_valid}, 32'd0);
  endtask

  // r11_: unmapped offset
  task automatic t_bad_offset();
    set_ctrl("R11", 32'h0100_0055);
    host_issue(1'b1, 5'h08, 32'hFFFF_FFFF);
    chk("R11", "error response", {31'd0, rsp_valid}, 32'd1);
    chk("R11", "error flag", {31'd0, rsp_err}, 32'd1);
    chk("R11", "no downstream", {31'd0, dn_valid}, 32'd0);
    host_issue(1'b0, 5'h00, '0);
    chk("R11", "word unchanged", rsp_rdata, 32'h0100_0055);
    chk("R11", "readback ok", {31'd0, rsp_err}, 32'd0);
  endtask

  initial begin
    t_reset();
    t_ctrl();
    t_page_fields();
    t_cycles();
    t_read();
    t_reuse();
    t_reserved();
    t_bad_offset();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      summary();
    end
  end

endmodule